// File: doc/BRIEF.md
# Polled Console Character Port

This block gives firmware a byte-wide console made of four registers on a simple register bus. The receive side has one holding byte. The transmit side has a small queue. Firmware works by polling. It reads the receive status, and when that status is nonzero it reads the receive data to take the character. Before it writes a character for transmission, it reads the transmit status and checks that it is nonzero.

The receive status read is the only event that asks the character source for a new byte. During that read, and only while the holding byte is empty, the block raises `rx_ready` for one cycle. If the source offers a byte in that cycle, the byte is captured and the same read already reports it. Transmit characters leave the queue through a valid/ready handshake toward the sink, in the order they were written.

Every register is 8 bits wide. Reads return a 32-bit word whose three upper bytes are zero. Baud-rate generation and serial framing belong outside this block.

Top module: `console_port_regs`

## Requirements
- R1: After synchronous reset, the following hold: `bus_rvalid` is 0, `tx_valid` is 0, `rx_ready` is 0, the receive holding byte is empty and the transmit queue is empty.
- R2: A read request (`bus_sel`=1, `bus_wr`=0) produces `bus_rvalid`=1 with `bus_rdata` in the following cycle. Bits 31:8 of `bus_rdata` are always 0. Any offset other than 16, 20 and 28 reads as 0, and that includes the write-only offset 24.
- R3: `rx_ready` is 1 only in a cycle that carries a read of offset 20 (receive status), and it is 1 in every such cycle while the holding byte is empty. A byte offered with `rx_valid`=1 in that cycle is captured.
- R4: A read of offset 20 returns 8'h01 if the holding byte was already full, or if a byte is captured by that same read. Otherwise it returns 8'h00.
- R5: A read of offset 16 (receive data) returns the held character and empties the holding byte. When the holding byte is empty, this read returns 8'h00.
- R6: While the holding byte is full, a receive status read does not raise `rx_ready`, so a pending byte at the source neither overwrites the held one nor is consumed.
- R7: A read of offset 28 (transmit status) returns 8'h01 while the queue holds fewer than TX_DEPTH characters and 8'h00 when it is full.
- R8: A write to offset 24 while the queue is not full appends `bus_wdata[7:0]`. Characters appear on `tx_data` with `tx_valid`=1 in write order, one cycle after the write request. They hold stable until accepted with `tx_ready`=1.
- R9: A write to offset 24 while the queue is full is discarded.
- R10: Writes to offsets 16, 20 and 28 change no state. Bits 31:8 of `bus_wdata` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| rx_valid | input | 1 | Source offers a character |
| rx_data | input | 8 | Offered character |
| rx_ready | output | 1 | Block accepts the offered character |
| tx_valid | output | 1 | A queued character is presented |
| tx_data | output | 8 | Presented character |
| tx_ready | input | 1 | Sink accepts the presented character |

## Verification
Read data is registered, so every read result is sampled on the falling edge that follows the request cycle. `rx_ready`, being combinational, is sampled 1 ns after the request is driven, inside the request cycle itself. A character written to the transmit queue is expected on `tx_data` at the falling edge after the write cycle. When draining, one character is counted at each falling edge with `tx_ready` held high, because each rising edge pops exactly one entry. The receive path is swept over all 256 character values, the transmit path likewise, and all 64 offsets are read to confirm the decode.

// File: rtl/cons_pkg.sv
package cons_pkg;

    localparam int unsigned OFF_IN_DATA  = 16;
    localparam int unsigned OFF_IN_STAT  = 20;
    localparam int unsigned OFF_OUT_DATA = 24;
    localparam int unsigned OFF_OUT_STAT = 28;

    localparam logic [7:0] STAT_USABLE = 8'h01;
    localparam logic [7:0] STAT_BLOCKED = 8'h00;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_IN_DATA,
        RS_IN_STAT,
        RS_OUT_DATA,
        RS_OUT_STAT
    } reg_sel_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        reg_sel_e   sel;
        logic [7:0] wbyte;
    } reg_op_t;

    function automatic logic [7:0] status_byte(input logic usable);
        return usable ? STAT_USABLE : STAT_BLOCKED;
    endfunction

endpackage

// File: rtl/cons_reg_decode.sv
module cons_reg_decode
    import cons_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        wbyte,
    output reg_op_t           op
);
    logic [31:0] offset;

    always_comb begin
        offset   = 32'(bus_addr);
        op.rd    = bus_sel && !bus_wr;
        op.wr    = bus_sel && bus_wr;
        op.wbyte = wbyte;
        if (!bus_sel)                  op.sel = RS_NONE;
        else if (offset == OFF_IN_DATA)  op.sel = RS_IN_DATA;
        else if (offset == OFF_IN_STAT)  op.sel = RS_IN_STAT;
        else if (offset == OFF_OUT_DATA) op.sel = RS_OUT_DATA;
        else if (offset == OFF_OUT_STAT) op.sel = RS_OUT_STAT;
        else                             op.sel = RS_NONE;
    end
endmodule

// File: rtl/cons_rx_hold.sv
module cons_rx_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       poll,
    input  logic       take,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       hold_full,
    output logic [7:0] hold_data,
    output logic       avail_now
);
    logic capture;

    assign rx_ready  = poll && !hold_full;
    assign capture   = rx_ready && rx_valid;
    assign avail_now = hold_full || capture;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= 8'h00;
        end else if (capture) begin
            hold_full <= 1'b1;
            hold_data <= rx_data;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end
endmodule

// File: rtl/cons_tx_fifo.sv
module cons_tx_fifo #(
    parameter int unsigned DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] push_data,
    output logic       has_room,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign has_room = count < CNT_W'(DEPTH);
    assign tx_valid = count != '0;
    assign tx_data  = mem[rd_ptr];
    assign do_push  = push && has_room;
    assign do_pop   = tx_valid && tx_ready;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= 8'h00;
                else if (do_push && wr_ptr == PTR_W'(i))
                    mem[i] <= push_data;
            end
        end
    endgenerate
endmodule

// File: rtl/console_port_regs.sv
module console_port_regs
    import cons_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned TX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);
    reg_op_t    op;
    logic       poll, take, push;
    logic       hold_full, avail_now, has_room;
    logic [7:0] hold_data, rd_byte;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:8];

    cons_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wbyte   (bus_wdata[7:0]),
        .op      (op)
    );

    assign poll = op.rd && op.sel == RS_IN_STAT;
    assign take = op.rd && op.sel == RS_IN_DATA;
    assign push = op.wr && op.sel == RS_OUT_DATA;

    cons_rx_hold u_rx (
        .clk      (clk),
        .rst      (rst),
        .poll     (poll),
        .take     (take),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .hold_full(hold_full),
        .hold_data(hold_data),
        .avail_now(avail_now)
    );

    cons_tx_fifo #(.DEPTH(TX_DEPTH)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_data(op.wbyte),
        .has_room (has_room),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready)
    );

    always_comb begin
        case (op.sel)
            RS_IN_DATA:  rd_byte = hold_full ? hold_data : 8'h00;
            RS_IN_STAT:  rd_byte = status_byte(avail_now);
            RS_OUT_STAT: rd_byte = status_byte(has_room);
            default:     rd_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= op.rd;
            bus_rdata  <= op.rd ? {24'h000000, rd_byte} : '0;
        end
    end
endmodule

// File: rtl/cons_port_checker.sv
module cons_port_checker
    import cons_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              hold_full
);
    logic stat_rd;
    assign stat_rd = bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_IN_STAT);

    a_r2_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    a_r2_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    a_r2_upper_bytes_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> bus_rdata[31:8] == 24'h0);

    a_r3_ready_only_on_poll: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> stat_rd);

    a_r4_status_is_flag_byte: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> bus_rdata[7:1] == 7'h0);

    a_r6_no_poll_while_holding: assert property (@(posedge clk) disable iff (rst)
        hold_full |-> !rx_ready);

    a_r8_tx_held_stable: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind console_port_regs cons_port_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .hold_full (hold_full)
);

// File: tb/tb_console_port_regs.sv
module tb_console_port_regs;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    console_port_regs #(.ADDR_W(ADDR_W), .TX_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input int a, output logic [31:0] d, output logic rdy);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        #1 rdy = rx_ready;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        check(bus_rvalid === 1'b1, "R2 rvalid", 32'(bus_rvalid), 32'd1);
    endtask

    task automatic bus_write(input int a, input logic [31:0] w);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_read(input int a, input logic [31:0] exp,
                               input logic exp_rdy, input string req);
        logic [31:0] d;
        logic        r;
        bus_read(a, d, r);
        check(d === exp, req, d, exp);
        check(r === exp_rdy, {req, " rx_ready"}, 32'(r), 32'(exp_rdy));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(bus_rvalid === 1'b0, "R1 rvalid", 32'(bus_rvalid), 0);
        check(tx_valid === 1'b0, "R1 tx_valid", 32'(tx_valid), 0);
        check(rx_ready === 1'b0, "R1 rx_ready", 32'(rx_ready), 0);
        expect_read(20, 32'h0, 1'b1, "R1 in-status empty");
        expect_read(28, 32'h1, 1'b0, "R1 out-status room");

        // R2 R3 offset sweep: only 16/20/28 readable, rx_ready only at 20
        for (int a = 0; a < 64; a++) begin
            logic [31:0] e;
            e = (a == 28) ? 32'h1 : 32'h0;
            expect_read(a, e, (a == 20), "R2 R3 offset decode");
        end

        // R3 R4 R5 R6 R10 receive sweep over every character
        for (int c = 0; c < 256; c++) begin
            logic [7:0] nxt;
            nxt = 8'(c) ^ 8'hA5;
            rx_valid = 1'b1; rx_data = 8'(c);
            expect_read(20, 32'h1, 1'b1, "R3 R4 capture on poll");
            rx_data = nxt;
            expect_read(20, 32'h1, 1'b0, "R6 no poll while full");
            bus_write(16, 32'h0000_00EE);
            bus_write(20, 32'h0000_0000);
            expect_read(16, 32'(c), 1'b0, "R5 R10 held char");
            expect_read(20, 32'h1, 1'b1, "R3 R4 next capture");
            expect_read(16, 32'(nxt), 1'b0, "R5 second char");
            rx_valid = 1'b0;
            expect_read(20, 32'h0, 1'b1, "R4 nothing offered");
            expect_read(16, 32'h0, 1'b0, "R5 empty read");
        end

        // R7 R9 R10 fill queue with sink stalled
        tx_ready = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            expect_read(28, (i < DEPTH) ? 32'h1 : 32'h0, 1'b0, "R7 out-status");
            bus_write(24, {24'hFFFFFF, 8'(8'h30 + i)});
        end
        expect_read(28, 32'h0, 1'b0, "R7 full");
        bus_write(28, 32'h1);
        expect_read(28, 32'h0, 1'b0, "R10 status write ignored");
        check(tx_valid === 1'b1 && tx_data === 8'h30, "R8 head held",
              {23'h0, tx_valid, tx_data}, 32'h130);

        // R8 R9 drain: exactly DEPTH characters in order
        begin
            int got;
            got = 0;
            tx_ready = 1'b1;
            for (int k = 0; k < DEPTH + 3; k++) begin
                if (tx_valid) begin
                    check(tx_data === 8'(8'h30 + got), "R8 order",
                          32'(tx_data), 32'(8'h30 + got));
                    got++;
                end
                @(negedge clk);
            end
            check(got == DEPTH, "R9 discarded when full", got, DEPTH);
        end
        expect_read(28, 32'h1, 1'b0, "R7 room after drain");

        // R8 transmit sweep with sink always ready
        for (int c = 0; c < 256; c++) begin
            bus_write(24, 32'(c));
            check(tx_valid === 1'b1 && tx_data === 8'(c), "R8 pass-through",
                  {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'(c)});
        end
        @(negedge clk);
        check(tx_valid === 1'b0, "R8 queue empty", 32'(tx_valid), 0);

        // R10 writes to read-only offsets send nothing
        bus_write(16, 32'h41); bus_write(20, 32'h42); bus_write(28, 32'h43);
        check(tx_valid === 1'b0, "R10 no send", 32'(tx_valid), 0);
        expect_read(20, 32'h0, 1'b1, "R10 rx untouched");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule